// File: doc/BRIEF.md
# Self-Routing Butterfly Switch Fabric

This block moves up to N packets per clock from N sources to N sinks through log2(N) columns of 2x2 switching elements. Each source presents a valid flag, a destination index and a payload. No central controller is involved: every column looks at one bit of each packet's destination index and steers the packet up or down. The first column uses the most significant bit and the last column uses the least significant bit, so a packet that survives all columns lands on the sink its destination names.

There is exactly one path from any source to any sink, so two packets can need the same element output. When that happens the packet on the element's upper input wins. The other packet is dropped and its source is flagged as blocked. The whole fabric is combinational, with one register stage at the outputs. Each sink reports a valid bit, the payload and the index of the source it came from. Each source reports whether its packet was blocked.

Top module: `bfly_fabric`

## Requirements
- R1: While `rst` is high at a clock edge, every bit of `out_valid` and `src_blocked` is 0 after that edge.
- R2: A valid packet from source i with destination d that meets no contention appears one clock later on sink d. There `out_valid[d]` is 1, the payload slice `d*DW +: DW` of `out_data` equals the input payload, and the slice `d*AW +: AW` of `out_src` equals i.
- R3: Column s (s = 0 for the column nearest the sources) pairs the lanes that differ only in bit AW-1-s of the lane index. A packet leaves the column on the lane whose bit AW-1-s equals bit AW-1-s of its destination. For example, sources 0 and 4 meet in column 0 and conflict only when their destinations share the top bit.
- R4: When both packets at an element want the same output, the packet on the lane whose examined index bit is 0 continues. The other packet is dropped, and `src_blocked` for its source is 1 one clock later.
- R5: Any destination pattern of the form d = i XOR c, with every source valid, is delivered with no blocked source. The identity pattern (c = 0) is one such case.
- R6: One clock after any cycle out of reset, the number of set `out_valid` bits plus the number of set `src_blocked` bits equals the number of set `in_valid` bits.
- R7: A source with `in_valid` 0 produces no output and is never flagged as blocked, whatever its destination and payload carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | N | Per-source packet present |
| in_dest | input | N*AW | Per-source destination index, source i at bits i*AW +: AW |
| in_data | input | N*DW | Per-source payload, source i at bits i*DW +: DW |
| out_valid | output | N | Per-sink packet delivered (registered) |
| out_data | output | N*DW | Per-sink payload (registered) |
| out_src | output | N*AW | Per-sink index of the originating source (registered) |
| src_blocked | output | N | Per-source packet dropped on contention (registered) |

## Verification
Every result is due exactly one clock after the inputs that caused it. This holds for delivered payloads, source tags and blocked flags alike, because the fabric is combinational up to a single output register. The bench drives inputs on a falling edge and lets one rising edge capture them. It then compares all four outputs at the next falling edge against a reference that follows each packet's lane column by column. The reset check uses the same one-edge spacing: inputs are held busy while reset is high across that edge.

// File: rtl/bfly_pkg.sv
package bfly_pkg;
  // Lane word layout, MSB first: {valid, dest[AW], src[AW], data[DW]}
  function automatic int lane_width(input int aw, input int dw);
    return 1 + 2 * aw + dw;
  endfunction

  // Destination bit examined by column s of an aw-column fabric
  function automatic int column_bit(input int s, input int aw);
    return aw - 1 - s;
  endfunction
endpackage

// File: rtl/bfly_element.sv
module bfly_element
  import bfly_pkg::*;
#(
  parameter int AW  = 3,
  parameter int DW  = 16,
  parameter int BIT = 2
) (
  input  logic [lane_width(AW, DW)-1:0] up_i,
  input  logic [lane_width(AW, DW)-1:0] dn_i,
  output logic [lane_width(AW, DW)-1:0] up_o,
  output logic [lane_width(AW, DW)-1:0] dn_o,
  output logic                          dn_lost_o
);
  localparam int W  = lane_width(AW, DW);
  localparam int VB = W - 1;
  localparam int SB = DW + AW + BIT;

  logic u_v, u_s, d_v, d_s;
  assign u_v = up_i[VB];
  assign u_s = up_i[SB];
  assign d_v = dn_i[VB];
  assign d_s = dn_i[SB];

  always_comb begin
    up_o      = '0;
    dn_o      = '0;
    dn_lost_o = 1'b0;
    if (u_v && !u_s) up_o = up_i;
    if (u_v &&  u_s) dn_o = up_i;
    if (d_v) begin
      if (u_v && (u_s == d_s)) dn_lost_o = 1'b1;
      else if (!d_s)           up_o = dn_i;
      else                     dn_o = dn_i;
    end
  end
endmodule

// File: rtl/bfly_column.sv
module bfly_column
  import bfly_pkg::*;
#(
  parameter int N   = 8,
  parameter int AW  = 3,
  parameter int DW  = 16,
  parameter int BIT = 2
) (
  input  logic [N-1:0][lane_width(AW, DW)-1:0] lane_i,
  output logic [N-1:0][lane_width(AW, DW)-1:0] lane_o,
  output logic [N-1:0]                         lost_o
);
  localparam int HALF = N / 2;
  localparam int LOWM = (1 << BIT) - 1;

  for (genvar p = 0; p < HALF; p++) begin : g_pair
    localparam int LO = ((p >> BIT) << (BIT + 1)) | (p & LOWM);
    localparam int HI = LO | (1 << BIT);
    bfly_element #(.AW(AW), .DW(DW), .BIT(BIT)) u_el (
      .up_i     (lane_i[LO]),
      .dn_i     (lane_i[HI]),
      .up_o     (lane_o[LO]),
      .dn_o     (lane_o[HI]),
      .dn_lost_o(lost_o[HI])
    );
    assign lost_o[LO] = 1'b0;
  end
endmodule

// File: rtl/bfly_fabric.sv
module bfly_fabric
  import bfly_pkg::*;
#(
  parameter int N  = 8,
  parameter int DW = 16,
  parameter int AW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    in_valid,
  input  logic [N*AW-1:0] in_dest,
  input  logic [N*DW-1:0] in_data,
  output logic [N-1:0]    out_valid,
  output logic [N*DW-1:0] out_data,
  output logic [N*AW-1:0] out_src,
  output logic [N-1:0]    src_blocked
);
  localparam int W  = lane_width(AW, DW);
  localparam int VB = W - 1;

  logic [AW:0][N-1:0][W-1:0] lanes;
  logic [AW-1:0][N-1:0]      lost;
  logic [N-1:0]              blocked_d;

  for (genvar i = 0; i < N; i++) begin : g_in
    assign lanes[0][i] = {in_valid[i], in_dest[i*AW +: AW], AW'(i), in_data[i*DW +: DW]};
  end

  for (genvar s = 0; s < AW; s++) begin : g_col
    bfly_column #(.N(N), .AW(AW), .DW(DW), .BIT(column_bit(s, AW))) u_col (
      .lane_i(lanes[s]),
      .lane_o(lanes[s+1]),
      .lost_o(lost[s])
    );
  end

  always_comb begin
    blocked_d = '0;
    for (int s = 0; s < AW; s++) begin
      for (int l = 0; l < N; l++) begin
        if (lost[s][l]) blocked_d[lanes[s][l][DW +: AW]] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= '0;
      src_blocked <= '0;
    end else begin
      src_blocked <= blocked_d;
      for (int k = 0; k < N; k++) out_valid[k] <= lanes[AW][k][VB];
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < N; k++) begin
      out_data[k*DW +: DW] <= lanes[AW][k][DW-1:0];
      out_src[k*AW +: AW]  <= lanes[AW][k][DW +: AW];
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (out_valid == '0 && src_blocked == '0));

  // R6
  conserve_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ($countones(out_valid) + $countones(src_blocked) == $countones($past(in_valid))));

  // R7
  idle_not_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((src_blocked & ~$past(in_valid)) == '0));

  for (genvar k = 0; k < N; k++) begin : g_chk
    for (genvar i = 0; i < N; i++) begin : g_src
      // R2
      delivery_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && out_valid[k] && out_src[k*AW +: AW] == AW'(i)) |->
          ($past(in_valid[i]) && $past(in_dest[i*AW +: AW]) == AW'(k) &&
           $past(in_data[i*DW +: DW]) == out_data[k*DW +: DW] && !src_blocked[i]));
    end
  end
endmodule

// File: tb/tb_bfly_fabric.sv
module tb_bfly_fabric;
  localparam int N  = 8;
  localparam int DW = 16;
  localparam int AW = 3;

  logic            clk = 1'b0;
  logic            rst;
  logic [N-1:0]    in_valid;
  logic [N*AW-1:0] in_dest;
  logic [N*DW-1:0] in_data;
  logic [N-1:0]    out_valid;
  logic [N*DW-1:0] out_data;
  logic [N*AW-1:0] out_src;
  logic [N-1:0]    src_blocked;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  logic [N-1:0]    e_v;
  logic [N*DW-1:0] e_d;
  logic [N*AW-1:0] e_s;
  logic [N-1:0]    e_b;

  always #5 clk = ~clk;

  bfly_fabric #(.N(N), .DW(DW)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_dest(in_dest), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .out_src(out_src), .src_blocked(src_blocked)
  );

  // Reference: follow each packet's lane column by column
  task automatic model();
    logic [N-1:0] alive;
    int pos[N];
    int nxt[N];
    alive = in_valid;
    for (int i = 0; i < N; i++) pos[i] = i;
    for (int s = 0; s < AW; s++) begin
      int b = AW - 1 - s;
      for (int i = 0; i < N; i++)
        nxt[i] = (pos[i] & ~(1 << b)) | (int'(in_dest[i*AW + b]) << b);
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++)
          if (i != j && alive[i] && alive[j] && nxt[i] == nxt[j] && ((pos[j] >> b) & 1) == 0)
            alive[i] = 1'b0;
      for (int i = 0; i < N; i++) pos[i] = nxt[i];
    end
    e_v = '0; e_d = '0; e_s = '0;
    for (int i = 0; i < N; i++) begin
      if (alive[i]) begin
        int d = int'(in_dest[i*AW +: AW]);
        e_v[d] = 1'b1;
        e_d[d*DW +: DW] = in_data[i*DW +: DW];
        e_s[d*AW +: AW] = AW'(i);
      end
    end
    e_b = in_valid & ~alive;
  endtask

  task automatic compare(input string tag);
    logic [N*DW-1:0] md, ed;
    logic [N*AW-1:0] ms, es;
    md = '0; ed = '0; ms = '0; es = '0;
    for (int k = 0; k < N; k++) if (e_v[k]) begin
      md[k*DW +: DW] = out_data[k*DW +: DW]; ed[k*DW +: DW] = e_d[k*DW +: DW];
      ms[k*AW +: AW] = out_src[k*AW +: AW];  es[k*AW +: AW] = e_s[k*AW +: AW];
    end
    tests++;
    if (out_valid !== e_v || src_blocked !== e_b || md !== ed || ms !== es) begin
      fails++;
      $display("FAIL %s: valid=%h blk=%h data=%h src=%h expected valid=%h blk=%h data=%h src=%h",
               tag, out_valid, src_blocked, md, ms, e_v, e_b, ed, es);
    end
  endtask

  task automatic apply(input string tag);
    model();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic set_pkt(input int i, input int d, input logic [DW-1:0] p);
    in_valid[i] = 1'b1;
    in_dest[i*AW +: AW] = AW'(d);
    in_data[i*DW +: DW] = p;
  endtask

  task automatic clear_in();
    in_valid = '0;
    in_dest = '0;
    in_data = '0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst = 1'b1;
    clear_in();
    // R1: reset with all sources busy clears outputs
    @(negedge clk);
    for (int i = 0; i < N; i++) set_pkt(i, i, 16'h1000 + 16'(i));
    @(negedge clk);
    e_v = '0; e_b = '0;
    compare("R1 reset");
    rst = 1'b0;

    // R2: lone packet 3 -> 6
    @(negedge clk); clear_in(); set_pkt(3, 6, 16'hBEEF); apply("R2 single");
    clear_in(); set_pkt(7, 0, 16'h0A0A); apply("R2 single corner");

    // R5: identity and xor permutations
    clear_in(); for (int i = 0; i < N; i++) set_pkt(i, i, 16'h2000 + 16'(i)); apply("R5 identity");
    e_b = 'x;
    if (src_blocked !== '0 || out_valid !== '1) begin
      fails++; $display("FAIL R5 identity full: valid=%h blk=%h expected valid=ff blk=00", out_valid, src_blocked);
    end
    tests++;
    clear_in(); for (int i = 0; i < N; i++) set_pkt(i, i ^ 5, 16'h3000 + 16'(i)); apply("R5 xor5");

    // R4: sources 0 and 4 both to 0 -> 0 wins, 4 blocked
    clear_in(); set_pkt(0, 0, 16'h0001); set_pkt(4, 0, 16'h0004); apply("R4 lower wins");
    tests++;
    if (src_blocked !== 8'h10) begin
      fails++; $display("FAIL R4 blocked: actual=%h expected=10", src_blocked);
    end
    // R4: last column conflict, sources 0 and 1 both to 5
    clear_in(); set_pkt(1, 5, 16'h0011); set_pkt(0, 5, 16'h0010); apply("R4 last column");

    // R3: top-bit split at column 0
    clear_in(); set_pkt(0, 2, 16'hA000); set_pkt(4, 5, 16'hA004); apply("R3 top bits differ");
    tests++;
    if (src_blocked !== '0) begin
      fails++; $display("FAIL R3 no conflict: actual=%h expected=00", src_blocked);
    end
    clear_in(); set_pkt(0, 1, 16'hB000); set_pkt(4, 3, 16'hB004); apply("R3 top bits equal");
    tests++;
    if (src_blocked !== 8'h10 || out_valid !== 8'h02) begin
      fails++; $display("FAIL R3 conflict: valid=%h blk=%h expected valid=02 blk=10", out_valid, src_blocked);
    end

    // R7: idle sources carrying colliding fields are ignored
    clear_in(); set_pkt(2, 4, 16'hC0DE);
    for (int i = 0; i < N; i++) if (i != 2) begin
      in_dest[i*AW +: AW] = 3'd4; in_data[i*DW +: DW] = 16'hDEAD;
    end
    apply("R7 idle ignored");

    // R1: reset mid-traffic
    for (int i = 0; i < N; i++) set_pkt(i, 7 - i, 16'h4000 + 16'(i));
    rst = 1'b1;
    @(negedge clk);
    e_v = '0; e_b = '0;
    compare("R1 mid reset");
    rst = 1'b0;

    // R6/R2: random traffic
    for (int t = 0; t < 400; t++) begin
      in_valid = N'($urandom);
      in_dest  = (N*AW)'({$urandom, $urandom});
      for (int i = 0; i < N; i++) in_data[i*DW +: DW] = DW'($urandom);
      apply("R6 random");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule